// File: doc/BRIEF.md
# Reset-Cause and Interrupt Flag Register

This block is the byte-wide status and flag register of a clock and reset unit. It holds sticky event flags for five events: the periodic tick timeout, a power-on reset, a low-voltage reset, any change of the PLL lock level and any change of the self-clock level. The same byte also shows the live lock, track and self-clock levels. Software reads the byte over a simple register bus and clears an event flag by writing a one to its bit. Writing a zero to a bit leaves that bit unchanged.

The two reset-cause flags sit in their own reset domain. Only the power-on reset clears that domain, so software can still read why the chip restarted after any system reset. Every other flag is cleared by either reset. The tick flag, gated by an enable input, drives the interrupt request. A second register at an adjacent address is reserved for test. In normal operation it reads as zero and ignores writes.

Top module: `rstflag_reg`

## Requirements
- R1: The flag byte sits at address FLAG_ADDR (default 0). Its bit positions are: 7 tick flag, 6 power-on flag, 5 low-voltage flag, 4 lock-change flag, 3 lock level, 2 track level, 1 self-clock-change flag, 0 self-clock level. Bits above 7 of `rdata` read 0. The read data follows `addr` combinationally.
- R2: A one-cycle pulse on `tick_evt` sets bit 7 at the next rising clock edge. The bit stays set until it is cleared.
- R3: A write to FLAG_ADDR with a one in an event-flag bit (7, 6, 5, 4 or 1) clears that flag at the clock edge. A zero in that bit leaves the flag unchanged.
- R4: If a set event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R5: `irq` is 1 exactly while bit 7 is 1 and `tick_ie` is 1 (default combinational variant).
- R6: Bits 3, 2 and 0 always read the current `lock_lvl`, `track_lvl` and `selfclk_lvl` levels. Writes to these bits have no effect.
- R7: Any change of `lock_lvl` sets bit 4 at the next clock edge, and any change of `selfclk_lvl` sets bit 1. A change seen in the first cycle after a reset is ignored, so levels that differ at reset release raise no flag.
- R8: Bit 6 is 1 after a power-on reset (`por_n` low). Bit 5 is set by a pulse on `lvr_evt`. The power-on reset clears bit 5. A system reset (`sys_rst_n` low) changes neither bit 6 nor bit 5.
- R9: The reserved test register at TEST_ADDR (default 1) always reads 0x00 and ignores writes. Every address other than FLAG_ADDR reads 0.
- R10: A system reset or a power-on reset clears bits 7, 4 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data; ones clear event flags |
| rdata | output | DATA_W | Read data of the addressed register |
| tick_ie | input | 1 | Tick interrupt enable |
| irq | output | 1 | Tick interrupt request |
| tick_evt | input | 1 | Tick timeout pulse |
| lvr_evt | input | 1 | Low-voltage reset occurred pulse |
| lock_lvl | input | 1 | PLL lock status level |
| track_lvl | input | 1 | PLL track status level |
| selfclk_lvl | input | 1 | Self-clock mode status level |

## Verification
The bound checker checks the following on every cycle: the write-one-clear and write-zero-hold rules of the tick flag, set priority over clear, interrupt gating, the live mirroring of the three levels, the zero read of the test address, the survival of the power-on flag through a system reset, and the clearing of system-domain flags during system reset. Some behaviour shows only in the bench's ordered scenarios. The first of these is the arming of the change detectors after a reset, where levels switched while reset was held must raise no flag. The others are the clearing of the low-voltage flag by a power-on reset only, and the readback of each flag after sequences of mixed events and clears.

// File: rtl/rstflag_pkg.sv
`timescale 1ns/1ps
package rstflag_pkg;

   // Width of the flag byte; the bit positions below are software-visible.
   localparam int unsigned REG_W = 8;

   localparam int unsigned POS_TICK  = 7;
   localparam int unsigned POS_POR   = 6;
   localparam int unsigned POS_LVR   = 5;
   localparam int unsigned POS_LKCHG = 4;
   localparam int unsigned POS_LOCK  = 3;
   localparam int unsigned POS_TRACK = 2;
   localparam int unsigned POS_SCCHG = 1;
   localparam int unsigned POS_SC    = 0;

   // Flags that live in the power-on domain and survive system reset.
   localparam logic [REG_W-1:0] POR_DOM_MASK =
      (REG_W'(1) << POS_POR) | (REG_W'(1) << POS_LVR);

   // Flags cleared by either reset.
   localparam logic [REG_W-1:0] SYS_DOM_MASK =
      (REG_W'(1) << POS_TICK) | (REG_W'(1) << POS_LKCHG) | (REG_W'(1) << POS_SCCHG);

   // Reset values of the power-on domain.
   localparam logic [REG_W-1:0] POR_RST_VAL = REG_W'(1) << POS_POR;

   // Number of status levels watched for changes.
   localparam int unsigned N_WATCH = 2;

endpackage

// File: rtl/rstflag_chg.sv
`timescale 1ns/1ps
// Change detector for W status levels. It arms one cycle after reset so that
// levels that differ from the flop reset value raise no flag.
module rstflag_chg #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] chg
);

   logic [W-1:0] prev_q;
   logic         armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= lvl;
         armed_q <= 1'b1;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign chg[i] = armed_q & (lvl[i] ^ prev_q[i]);
   end

endmodule

// File: rtl/rstflag_bank.sv
`timescale 1ns/1ps
// Write-one-clear flag bank for one reset domain. Only the bits in KEEP_MASK
// hold state; a set wins over a clear in the same cycle.
module rstflag_bank #(
   parameter int unsigned     W         = 8,
   parameter logic [W-1:0]    KEEP_MASK = '0,
   parameter logic [W-1:0]    RST_VAL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] q
);

   if ((RST_VAL & ~KEEP_MASK) != '0) begin : g_bad_rst
      $error("rstflag_bank: reset value outside kept bits");
   end

   logic [W-1:0] nxt;

   always_comb begin
      nxt = ((q & ~clr_vec) | set_vec) & KEEP_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

endmodule

// File: rtl/rstflag_rdmux.sv
`timescale 1ns/1ps
// Read decoder: the flag word at FLAG_ADDR, zero everywhere else (the test
// register included).
module rstflag_rdmux #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned FLAG_ADDR = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  word,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

   always_comb begin
      rdata = '0;
      if (addr == FLAG_A) rdata[REG_W-1:0] = word;
   end

endmodule

// File: rtl/rstflag_reg.sv
`timescale 1ns/1ps
module rstflag_reg
   import rstflag_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned FLAG_ADDR = 0,
   parameter int unsigned TEST_ADDR = 1,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tick_ie,
   output logic              irq,
   input  logic              tick_evt,
   input  logic              lvr_evt,
   input  logic              lock_lvl,
   input  logic              track_lvl,
   input  logic              selfclk_lvl
);

   localparam int unsigned     ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] FLAG_A  = ADDR_W'(FLAG_ADDR);

   // Elaboration-time parameter checks.
   if (DATA_W < REG_W) begin : g_chk_dw
      $error("rstflag_reg: DATA_W must hold the flag byte");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_chk_aw
      $error("rstflag_reg: ADDR_W out of range");
   end
   if (FLAG_ADDR >= ADDR_SPAN || TEST_ADDR >= ADDR_SPAN) begin : g_chk_span
      $error("rstflag_reg: register address outside address space");
   end
   if (FLAG_ADDR == TEST_ADDR) begin : g_chk_overlap
      $error("rstflag_reg: flag and test registers share an address");
   end

   // System-domain flags fall on either reset.
   logic rst_all_n;
   assign rst_all_n = por_n & sys_rst_n;

   // Change detection on the watched levels.
   logic [N_WATCH-1:0] watch_lvl;
   logic [N_WATCH-1:0] watch_chg;
   assign watch_lvl = {selfclk_lvl, lock_lvl};

   rstflag_chg #(.W(N_WATCH)) u_chg (
      .clk  (clk),
      .rst_n(rst_all_n),
      .lvl  (watch_lvl),
      .chg  (watch_chg)
   );

   // Set and clear vectors in flag-byte positions.
   logic             flag_wr;
   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;

   assign flag_wr = wr_en & (addr == FLAG_A);
   assign clr_vec = {REG_W{flag_wr}} & wdata[REG_W-1:0];

   always_comb begin
      set_vec            = '0;
      set_vec[POS_TICK]  = tick_evt;
      set_vec[POS_LVR]   = lvr_evt;
      set_vec[POS_LKCHG] = watch_chg[0];
      set_vec[POS_SCCHG] = watch_chg[1];
   end

   // Two banks, one per reset domain.
   logic [REG_W-1:0] por_q;
   logic [REG_W-1:0] sys_q;

   rstflag_bank #(
      .W        (REG_W),
      .KEEP_MASK(POR_DOM_MASK),
      .RST_VAL  (POR_RST_VAL)
   ) u_por_bank (
      .clk    (clk),
      .rst_n  (por_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .q      (por_q)
   );

   rstflag_bank #(
      .W        (REG_W),
      .KEEP_MASK(SYS_DOM_MASK),
      .RST_VAL  ('0)
   ) u_sys_bank (
      .clk    (clk),
      .rst_n  (rst_all_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .q      (sys_q)
   );

   // Live levels in their read positions.
   logic [REG_W-1:0] lvl_word;
   always_comb begin
      lvl_word            = '0;
      lvl_word[POS_LOCK]  = lock_lvl;
      lvl_word[POS_TRACK] = track_lvl;
      lvl_word[POS_SC]    = selfclk_lvl;
   end

   logic [REG_W-1:0] flag_word;
   assign flag_word = por_q | sys_q | lvl_word;

   rstflag_rdmux #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_W    (REG_W),
      .FLAG_ADDR(FLAG_ADDR)
   ) u_rdmux (
      .addr (addr),
      .word (flag_word),
      .rdata(rdata)
   );

   // Interrupt request: combinational or registered variant.
   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_all_n) begin
         if (!rst_all_n) irq_q <= 1'b0;
         else            irq_q <= flag_word[POS_TICK] & tick_ie;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = flag_word[POS_TICK] & tick_ie;
   end

endmodule

// File: rtl/rstflag_reg_chk.sv
`timescale 1ns/1ps
module rstflag_reg_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned FLAG_ADDR = 0,
   parameter int unsigned TEST_ADDR = 1,
   parameter bit          IRQ_REG   = 1'b0
) (
   input logic              clk,
   input logic              por_n,
   input logic              sys_rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              tick_ie,
   input logic              irq,
   input logic              tick_evt,
   input logic              lock_lvl,
   input logic              track_lvl,
   input logic              selfclk_lvl,
   input logic [7:0]        flags
);

   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] TEST_A = ADDR_W'(TEST_ADDR);

   logic clr_tick;
   logic clr_por;
   assign clr_tick = wr_en && (addr == FLAG_A) && wdata[7];
   assign clr_por  = wr_en && (addr == FLAG_A) && wdata[6];

   p_tick_set_r2: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
      tick_evt |=> flags[7]);

   p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
      (clr_tick && !tick_evt) |=> !flags[7]);

   p_w0_keep_r3: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
      (flags[7] && !clr_tick) |=> flags[7]);

   p_set_wins_r4: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
      (tick_evt && clr_tick) |=> flags[7]);

   if (!IRQ_REG) begin : g_irq_props
      p_irq_gate_r5: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
         irq |-> tick_ie);
      p_irq_raise_r5: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
         (flags[7] && tick_ie) |-> irq);
   end

   p_lvl_mirror_r6: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
      (flags[3] == lock_lvl) && (flags[2] == track_lvl) && (flags[0] == selfclk_lvl));

   p_por_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      ($past(flags[6]) && !$past(clr_por)) |-> flags[6]);

   p_test_zero_r9: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
      (addr == TEST_A) |-> (rdata == '0));

   p_sys_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst_n |-> (!flags[7] && !flags[4] && !flags[1]));

endmodule

bind rstflag_reg rstflag_reg_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .FLAG_ADDR(FLAG_ADDR),
   .TEST_ADDR(TEST_ADDR),
   .IRQ_REG  (IRQ_REG)
) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .sys_rst_n  (sys_rst_n),
   .addr       (addr),
   .wr_en      (wr_en),
   .wdata      (wdata),
   .rdata      (rdata),
   .tick_ie    (tick_ie),
   .irq        (irq),
   .tick_evt   (tick_evt),
   .lock_lvl   (lock_lvl),
   .track_lvl  (track_lvl),
   .selfclk_lvl(selfclk_lvl),
   .flags      (flag_word)
);

// File: tb/rstflag_reg_tb.sv
`timescale 1ns/1ps
module rstflag_reg_tb;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tick_ie = 1'b0;
   logic       irq;
   logic       tick_evt = 1'b0;
   logic       lvr_evt = 1'b0;
   logic       lock_lvl = 1'b0;
   logic       track_lvl = 1'b0;
   logic       selfclk_lvl = 1'b0;

   always #2 clk = ~clk;

   rstflag_reg u_dut (
      .clk        (clk),
      .por_n      (por_n),
      .sys_rst_n  (sys_rst_n),
      .addr       (addr),
      .wr_en      (wr_en),
      .wdata      (wdata),
      .rdata      (rdata),
      .tick_ie    (tick_ie),
      .irq        (irq),
      .tick_evt   (tick_evt),
      .lvr_evt    (lvr_evt),
      .lock_lvl   (lock_lvl),
      .track_lvl  (track_lvl),
      .selfclk_lvl(selfclk_lvl)
   );

   typedef struct {
      logic [7:0] exp;
      bit         on_irq;
      string      tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int       n_chk = 0;
   int       n_err = 0;
   bit       rd_valid = 1'b0;
   bit       done = 1'b0;

   // Monitor: pops one expected item per strobed cycle, 1 ns after negedge.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rd_valid && sb_q.size() > 0) begin
            sb_item_t   it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.on_irq ? {7'b0, irq} : rdata;
            n_chk++;
            if (act !== it.exp) begin
               n_err++;
               $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push_exp(input logic [7:0] e, input bit on_irq, input string tag);
      sb_item_t it;
      it.exp    = e;
      it.on_irq = on_irq;
      it.tag    = tag;
      sb_q.push_back(it);
      rd_valid = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      addr = a;
      push_exp(e, 1'b0, tag);
   endtask

   task automatic expect_irq(input logic e, input string tag);
      @(negedge clk);
      push_exp({7'b0, e}, 1'b1, tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input bit do_tick, input bit do_lvr, input bit do_wr, input logic [7:0] d);
      @(negedge clk);
      tick_evt = do_tick;
      lvr_evt  = do_lvr;
      if (do_wr) begin
         addr  = 4'd0;
         wdata = d;
         wr_en = 1'b1;
      end
      @(negedge clk);
      tick_evt = 1'b0;
      lvr_evt  = 1'b0;
      wr_en    = 1'b0;
   endtask

   task automatic set_lvl(input logic lk, input logic tr, input logic sc);
      @(negedge clk);
      lock_lvl    = lk;
      track_lvl   = tr;
      selfclk_lvl = sc;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n     = 1'b1;
      sys_rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Reset state: only the power-on flag is up.
      expect_rd(4'd0, 8'h40, "R1 R8 reset value");
      expect_irq(1'b0, "R5 no request after reset");

      // Test register and unused address.
      expect_rd(4'd1, 8'h00, "R9 test reg reads zero");
      wr(4'd1, 8'hFF);
      expect_rd(4'd1, 8'h00, "R9 test reg ignores write");
      expect_rd(4'd0, 8'h40, "R9 test write leaves flags");
      expect_rd(4'd5, 8'h00, "R9 unused address reads zero");

      // Writing zeros changes nothing.
      wr(4'd0, 8'h00);
      expect_rd(4'd0, 8'h40, "R3 write zero keeps flags");

      // Tick flag and interrupt gating.
      pulse(1'b1, 1'b0, 1'b0, 8'h00);
      expect_rd(4'd0, 8'hC0, "R2 tick sets bit7");
      expect_irq(1'b0, "R5 request masked when disabled");
      tick_ie = 1'b1;
      expect_irq(1'b1, "R5 request raised when enabled");

      // Clearing other bits and read-only bits leaves tick set.
      wr(4'd0, 8'h0F);
      expect_rd(4'd0, 8'hC0, "R3 R6 other-bit write keeps tick");
      wr(4'd0, 8'h80);
      expect_rd(4'd0, 8'h40, "R3 write one clears tick");
      expect_irq(1'b0, "R5 request drops after clear");

      // Set beats clear.
      pulse(1'b1, 1'b0, 1'b1, 8'h80);
      expect_rd(4'd0, 8'hC0, "R4 tick set wins over clear");
      wr(4'd0, 8'h80);
      expect_rd(4'd0, 8'h40, "R3 tick cleared again");

      // Lock level change and mirroring.
      set_lvl(1'b1, 1'b0, 1'b0);
      expect_rd(4'd0, 8'h58, "R6 R7 lock rise mirrors and flags");
      set_lvl(1'b1, 1'b1, 1'b0);
      expect_rd(4'd0, 8'h5C, "R6 track mirrors without flag");
      wr(4'd0, 8'h9F);
      expect_rd(4'd0, 8'h4C, "R3 R6 clear change flag, levels stay");
      set_lvl(1'b0, 1'b1, 1'b0);
      expect_rd(4'd0, 8'h54, "R7 lock fall flags");
      wr(4'd0, 8'h10);
      expect_rd(4'd0, 8'h44, "R3 lock change flag cleared");

      // Self-clock level change.
      set_lvl(1'b0, 1'b1, 1'b1);
      expect_rd(4'd0, 8'h47, "R7 self-clock rise flags");
      wr(4'd0, 8'h02);
      expect_rd(4'd0, 8'h45, "R3 self-clock change flag cleared");

      // Low-voltage flag.
      pulse(1'b0, 1'b1, 1'b0, 8'h00);
      expect_rd(4'd0, 8'h65, "R8 low-voltage event sets bit5");

      // System reset with level changes held inside it.
      pulse(1'b1, 1'b0, 1'b0, 8'h00);
      expect_rd(4'd0, 8'hE5, "R2 tick before system reset");
      @(negedge clk);
      sys_rst_n   = 1'b0;
      lock_lvl    = 1'b1;
      selfclk_lvl = 1'b0;
      repeat (3) @(negedge clk);
      sys_rst_n = 1'b1;
      repeat (3) @(negedge clk);
      expect_rd(4'd0, 8'h6C, "R8 R10 R7 system reset keeps cause flags only");
      expect_irq(1'b0, "R10 request gone after system reset");

      // Clear cause flags, then power-on reset.
      wr(4'd0, 8'h60);
      expect_rd(4'd0, 8'h0C, "R3 R8 cause flags cleared by write");
      pulse(1'b0, 1'b1, 1'b0, 8'h00);
      @(negedge clk);
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      repeat (3) @(negedge clk);
      expect_rd(4'd0, 8'h4C, "R8 power-on sets bit6 clears bit5");

      // Set beats clear on a cause flag.
      pulse(1'b0, 1'b1, 1'b1, 8'h20);
      expect_rd(4'd0, 8'h6C, "R4 low-voltage set wins over clear");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule